// File: doc/BRIEF.md
# Split-Half Pattern Register with Phase Sequencer

This block is a Fibonacci pseudorandom pattern register whose state is cut into an upper half and a lower half that never change in the same clock cycle. A sequencer running on the main clock produces three phase enables, one per cycle at most, in a repeating four-cycle schedule of upper phase, lower phase (two cycles), output phase. The upper phase shifts the upper half and captures the feedback bit into a connector flip-flop. The lower phase shifts that connector bit into the lower half on its closing cycle. The output phase is a pulse that a downstream transition-reducing stage uses to emit its vector.

Each full schedule therefore makes exactly one conventional register step, while at most half of the state bits toggle on any single edge. A seed can be loaded at any time and restarts the schedule. The enable input freezes the whole block in place.

Top module: `tsl_lfsr`

## Requirements
- R1: While rst_ni is low and on release, state_o equals the parameter RST_SEED (default 8'h91), phase_o is 3'b000 and vld_o is 0; the schedule starts at the upper phase.
- R2: phase_o bit 0 is the upper phase, bit 1 the lower phase, bit 2 the output phase; at most one bit is ever set, and all bits are 0 when en_i is low or load_i is high.
- R3: Over consecutive cycles with en_i high and load_i low, phase_o repeats 3'b001, 3'b010, 3'b010, 3'b100.
- R4: At the edge closing an upper-phase cycle, the upper half (bits WIDTH-1 down to WIDTH/2) takes old state bits WIDTH-2 down to WIDTH/2-1, and the lower half holds.
- R5: The first lower-phase cycle changes no state bit; at the edge closing the second lower-phase cycle the lower half shifts left by one, taking the connector bit into bit 0, and the upper half holds.
- R6: After one full schedule, state_o equals one Fibonacci step of the state it started from: shift left by one with bit 0 set to the XOR of the old bits selected by TAPS (default 8'hB8, bits 7, 5, 4, 3).
- R7: vld_o is 1 exactly in the cycle after the lower half updates, which is the output-phase cycle, and 0 otherwise.
- R8: With en_i low and load_i low, state_o, vld_o-free schedule position and connector hold and phase_o is 0; when en_i returns high the schedule resumes at the step where it stopped.
- R9: load_i high at an edge sets state_o to seed_i, clears vld_o and restarts the schedule at the upper phase, whatever en_i is.
- R10: With the default TAPS, a nonzero state returns to itself after exactly 255 full schedules and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable for the sequencer and segments |
| load_i | input | 1 | Load seed_i and restart the schedule |
| seed_i | input | WIDTH | Seed value |
| state_o | output | WIDTH | Current register contents |
| phase_o | output | 3 | One-hot phase enables: upper, lower, output |
| vld_o | output | 1 | Whole state has just completed a step |

## Verification
The bench goes after the half-updated state between the upper phase and the lower commit: a design that shifted both halves at once, or that computed the feedback after the upper half had moved, would show the wrong mixed value or a wrong step. It freezes the block in the middle of the lower window, where a sequencer that lost its position or a lower half that committed on the first lower cycle would produce a double shift or skip. It loads seeds mid-schedule and with the enable low, which catches a counter that does not restart, and sweeps every nonzero seed plus a full 255-step period, which exposes a wrong tap or a connector wired to the wrong bit.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [1:0] {
    STEP_UP  = 2'd0,
    STEP_LO0 = 2'd1,
    STEP_LO1 = 2'd2,
    STEP_OUT = 2'd3
  } step_e;

  localparam int PH_UP  = 0;
  localparam int PH_LO  = 1;
  localparam int PH_OUT = 2;
  localparam int NUM_PH = 3;
endpackage

// File: rtl/tsl_phase_seq.sv
module tsl_phase_seq
  import tsl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                load_i,
  output logic [NUM_PH-1:0]   phase_o,
  output logic                lo_commit_o,
  output step_e               step_o
);
  step_e step_q;
  logic  go;

  assign go = en_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_q <= STEP_UP;
    else if (load_i) step_q <= STEP_UP;
    else if (en_i)   step_q <= step_e'(step_q + 2'd1);
  end

  always_comb begin
    phase_o         = '0;
    phase_o[PH_UP]  = go && (step_q == STEP_UP);
    phase_o[PH_LO]  = go && ((step_q == STEP_LO0) || (step_q == STEP_LO1));
    phase_o[PH_OUT] = go && (step_q == STEP_OUT);
  end

  // lower half commits on the closing cycle of its window
  assign lo_commit_o = go && (step_q == STEP_LO1);
  assign step_o      = step_q;

  // R2
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_o));
  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[PH_OUT] |=> (step_q == STEP_UP));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(step_q));
  // R9
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (step_q == STEP_UP));
endmodule

// File: rtl/tsl_segment.sv
module tsl_segment #(
  parameter int             W   = 4,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         upd_i,
  input  logic         shift_in_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= RST;
    else if (load_i) q_q <= load_val_i;
    else if (upd_i)  q_q <= {q_q[W-2:0], shift_in_i};
  end

  assign q_o = q_q;

  // R8
  seg_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !upd_i) |=> $stable(q_o));
endmodule

// File: rtl/tsl_lfsr.sv
module tsl_lfsr
  import tsl_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] TAPS     = 8'hB8,
  parameter logic [WIDTH-1:0] RST_SEED = 8'h91
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic [WIDTH-1:0] state_o,
  output logic [2:0]       phase_o,
  output logic             vld_o
);
  localparam int LO_W = WIDTH / 2;
  localparam int UP_W = WIDTH - LO_W;

  logic [NUM_PH-1:0] phase;
  logic              lo_commit;
  step_e             step;
  logic [UP_W-1:0]   up_q;
  logic [LO_W-1:0]   lo_q;
  logic              conn_q;
  logic              vld_q;
  logic              fb;

  tsl_phase_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .load_i     (load_i),
    .phase_o    (phase),
    .lo_commit_o(lo_commit),
    .step_o     (step)
  );

  // feedback snapshot taken while both halves still hold the old state
  assign fb = ^(state_o & TAPS);

  tsl_segment #(.W(UP_W), .RST(RST_SEED[WIDTH-1:LO_W])) u_up (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .load_val_i(seed_i[WIDTH-1:LO_W]),
    .upd_i     (phase[PH_UP]),
    .shift_in_i(lo_q[LO_W-1]),
    .q_o       (up_q)
  );

  tsl_segment #(.W(LO_W), .RST(RST_SEED[LO_W-1:0])) u_lo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .load_val_i(seed_i[LO_W-1:0]),
    .upd_i     (lo_commit),
    .shift_in_i(conn_q),
    .q_o       (lo_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (load_i) begin
      conn_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      if (phase[PH_UP]) conn_q <= fb;
      vld_q <= lo_commit;
    end
  end

  assign state_o = {up_q, lo_q};
  assign phase_o = phase;
  assign vld_o   = vld_q;

  // R4
  up_lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase[PH_UP] && !load_i) |=> $stable(lo_q));
  // R5
  lo_up_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase[PH_LO] |=> $stable(up_q));
  // R7
  vld_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (step == STEP_OUT));
  // R9
  load_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (state_o == $past(seed_i)) && !vld_o);
endmodule

// File: tb/tsl_lfsr_tb_top.sv
`timescale 1ns/1ps
module tsl_lfsr_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] seed_i = 8'h00;
  logic [7:0] state_o;
  logic [2:0] phase_o;
  logic       vld_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  tsl_lfsr dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .load_i (load_i),
    .seed_i (seed_i),
    .state_o(state_o),
    .phase_o(phase_o),
    .vld_o  (vld_o)
  );

  function automatic logic [7:0] nxt(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // starts at a negedge with the schedule at the upper phase
  task automatic run_schedule(input logic [7:0] cur, output logic [7:0] nx);
    nx = nxt(cur);
    check("R3 up phase", phase_o, 3'b001);
    check("R6 start state", state_o, cur);
    check("R7 vld low", vld_o, 0);
    tick();
    check("R3 lo phase 1", phase_o, 3'b010);
    check("R4 upper shifted", state_o, {cur[6:3], cur[3:0]});
    tick();
    check("R3 lo phase 2", phase_o, 3'b010);
    check("R5 first lo no change", state_o, {cur[6:3], cur[3:0]});
    check("R7 vld low b", vld_o, 0);
    tick();
    check("R3 out phase", phase_o, 3'b100);
    check("R6 full step", state_o, nx);
    check("R7 vld high", vld_o, 1);
    tick();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] cur, nx, mid;
    int first_ret;
    repeat (3) tick();
    check("R1 reset state", state_o, 8'h91);
    check("R1 reset phase", phase_o, 3'b000);
    check("R1 reset vld", vld_o, 0);
    rst_ni = 1'b1;
    repeat (2) begin
      tick();
      check("R8 idle state", state_o, 8'h91);
      check("R2 idle phase", phase_o, 3'b000);
    end
    en_i = 1'b1;
    #1;
    cur = 8'h91;
    // R10 full period
    first_ret = 0;
    for (int i = 1; i <= 255; i++) begin
      run_schedule(cur, nx);
      cur = nx;
      if (state_o == 8'h91 && first_ret == 0) first_ret = i;
    end
    check("R10 period", first_ret, 255);

    // R8 freeze inside the lower window
    check("R3 up before freeze", phase_o, 3'b001);
    tick();
    mid = {cur[6:3], cur[3:0]};
    check("R4 upper before freeze", state_o, mid);
    tick();
    en_i = 1'b0;
    #1;
    check("R8 phase gated", phase_o, 3'b000);
    repeat (3) begin
      tick();
      check("R8 frozen state", state_o, mid);
      check("R8 frozen phase", phase_o, 3'b000);
      check("R8 frozen vld", vld_o, 0);
    end
    en_i = 1'b1;
    #1;
    check("R8 resume lo", phase_o, 3'b010);
    tick();
    check("R8 resume commit", state_o, nxt(cur));
    check("R8 resume out", phase_o, 3'b100);
    check("R7 vld after resume", vld_o, 1);
    tick();
    cur = nxt(cur);

    // R9 load mid-schedule
    tick();
    load_i = 1'b1;
    seed_i = 8'h3C;
    #1;
    check("R2 phase gated by load", phase_o, 3'b000);
    tick();
    load_i = 1'b0;
    check("R9 loaded", state_o, 8'h3C);
    check("R9 vld cleared", vld_o, 0);
    #1;
    check("R9 restart up", phase_o, 3'b001);
    run_schedule(8'h3C, nx);

    // R9 load with enable low
    en_i = 1'b0;
    load_i = 1'b1;
    seed_i = 8'h5A;
    tick();
    load_i = 1'b0;
    check("R9 load en low", state_o, 8'h5A);
    en_i = 1'b1;
    #1;
    run_schedule(8'h5A, nx);

    // R6 sweep all nonzero seeds
    for (int s = 1; s < 256; s++) begin
      load_i = 1'b1;
      seed_i = 8'(s);
      tick();
      load_i = 1'b0;
      #1;
      run_schedule(8'(s), nx);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule